// File: doc/BRIEF.md
# Dual-Byte Sound Command Bridge

This block carries commands from a 16-bit host processor to an 8-bit sound processor. One host write stores both halves of a 16-bit word at once: the upper byte goes to the player-one command slot and the lower byte to the player-two command slot. The same write raises a one-cycle non-maskable interrupt request toward the sound processor and drops a ready flag.

The sound processor reads each command slot through its 8-bit I/O space. It acknowledges a command by reading a dedicated clear address, which raises the ready flag again. The host polls that flag through one bit of its status word, so it knows when the sound side has taken the last command. Both sides run on one clock.

Top module: `snd_cmd_bridge`

## Requirements
- R1: A host write (`host_wr_i` high at a rising edge) stores `host_wdata_i[15:8]` in command slot 0 and `host_wdata_i[7:0]` in command slot 1. Both values are readable after that edge.
- R2: `snd_nmi_o` is high for exactly the one cycle that follows each host write edge, and it is low at every other time.
- R3: A host write sets the ready flag to 0 from the next cycle onward.
- R4: Only `snd_addr_i[7:0]` is decoded. The upper address bits have no effect on read data or on the acknowledge.
- R5: A sound read at I/O address 0x00 returns slot 0, and a read at 0x04 returns slot 1, combinationally. A read at any other address returns 0xFF.
- R6: Sound-side writes at any address, including 0x00 and 0x0C, leave both slots and the ready flag unchanged.
- R7: A sound read at address 0x0C (`snd_rd_i` high at an edge) sets the ready flag to 1 from the next cycle onward.
- R8: `host_status_o` bit 5 equals the ready flag, active high. All other status bits are 0.
- R9: While `rst_ni` is low, both slots are 0x00, the ready flag is 1 and `snd_nmi_o` is 0.
- R10: When an acknowledge read and a host write meet at the same edge, the write wins and the ready flag is 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by host and sound sides |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_wr_i | input | 1 | Host command write strobe |
| host_wdata_i | input | 16 | Host command word |
| host_status_o | output | 16 | Host status word; bit 5 is the ready flag |
| snd_addr_i | input | 16 | Sound-side I/O address (low 8 bits decoded) |
| snd_rd_i | input | 1 | Sound-side I/O read strobe |
| snd_wr_i | input | 1 | Sound-side I/O write strobe (ignored) |
| snd_rdata_o | output | 8 | Sound-side I/O read data |
| snd_nmi_o | output | 1 | Non-maskable interrupt request to the sound processor |

## Verification
The bench builds the block with its default parameters: two 8-bit slots, a 16-bit sound address of which 8 bits are decoded, and the ready flag on status bit 5. The 16-bit address lets the bench put nonzero values in the upper address byte and confirm that they alias onto the 8-bit decode. The bench also drives an acknowledge and a host write at the same edge to check that the write takes priority, and it checks that back-to-back host writes each produce their own interrupt cycle.

// File: rtl/snd_bridge_pkg.sv
package snd_bridge_pkg;
  localparam logic [7:0] SLOT_BASE  = 8'h00;
  localparam int         SLOT_STEP  = 4;
  localparam logic [7:0] ACK_ADDR   = 8'h0C;
  localparam logic [7:0] FLOAT_DATA = 8'hFF;
endpackage

// File: rtl/snd_cmd_slot.sv
module snd_cmd_slot #(
  parameter int CMD_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CMD_W-1:0] d_i,
  output logic [CMD_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/snd_io_decode.sv
module snd_io_decode
  import snd_bridge_pkg::*;
#(
  parameter int NUM_SLOT = 2,
  parameter int CMD_W    = 8,
  parameter int DEC_W    = 8
) (
  input  logic [DEC_W-1:0]          addr_i,
  input  logic                      rd_i,
  input  logic [NUM_SLOT*CMD_W-1:0] slots_i,
  output logic [CMD_W-1:0]          rdata_o,
  output logic                      ack_o
);
  logic [NUM_SLOT-1:0] hit;

  for (genvar i = 0; i < NUM_SLOT; i++) begin : g_hit
    localparam logic [DEC_W-1:0] SlotAddr = DEC_W'(SLOT_BASE) + DEC_W'(i * SLOT_STEP);
    assign hit[i] = (addr_i == SlotAddr);
  end

  always_comb begin
    rdata_o = CMD_W'(FLOAT_DATA);
    for (int i = 0; i < NUM_SLOT; i++) begin
      if (hit[i]) rdata_o = slots_i[i*CMD_W +: CMD_W];
    end
  end

  assign ack_o = rd_i && (addr_i == DEC_W'(ACK_ADDR));
endmodule

// File: rtl/snd_handshake.sv
module snd_handshake (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic host_wr_i,
  input  logic ack_i,
  output logic nmi_o,
  output logic ready_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_o   <= 1'b0;
      ready_o <= 1'b1;
    end else begin
      nmi_o <= host_wr_i;
      // host write outranks a same-cycle acknowledge
      if (host_wr_i)  ready_o <= 1'b0;
      else if (ack_i) ready_o <= 1'b1;
    end
  end
endmodule

// File: rtl/snd_cmd_bridge.sv
module snd_cmd_bridge #(
  parameter int NUM_SLOT = 2,
  parameter int CMD_W    = 8,
  parameter int ADDR_W   = 16,
  parameter int DEC_W    = 8,
  parameter int STAT_W   = 16,
  parameter int RDY_BIT  = 5
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       host_wr_i,
  input  logic [NUM_SLOT*CMD_W-1:0]  host_wdata_i,
  output logic [STAT_W-1:0]          host_status_o,
  input  logic [ADDR_W-1:0]          snd_addr_i,
  input  logic                       snd_rd_i,
  input  logic                       snd_wr_i,
  output logic [CMD_W-1:0]           snd_rdata_o,
  output logic                       snd_nmi_o
);
  localparam int HostW = NUM_SLOT * CMD_W;

  logic [HostW-1:0] slots;
  logic             ack;
  logic             ready;
  logic             unused_snd;

  // slot 0 takes the most significant byte of the host word
  for (genvar i = 0; i < NUM_SLOT; i++) begin : g_slot
    snd_cmd_slot #(.CMD_W(CMD_W)) u_slot (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .we_i  (host_wr_i),
      .d_i   (host_wdata_i[(NUM_SLOT-1-i)*CMD_W +: CMD_W]),
      .q_o   (slots[i*CMD_W +: CMD_W])
    );
  end

  snd_io_decode #(.NUM_SLOT(NUM_SLOT), .CMD_W(CMD_W), .DEC_W(DEC_W)) u_dec (
    .addr_i (snd_addr_i[DEC_W-1:0]),
    .rd_i   (snd_rd_i),
    .slots_i(slots),
    .rdata_o(snd_rdata_o),
    .ack_o  (ack)
  );

  snd_handshake u_hs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .host_wr_i(host_wr_i),
    .ack_i    (ack),
    .nmi_o    (snd_nmi_o),
    .ready_o  (ready)
  );

  always_comb begin
    host_status_o          = '0;
    host_status_o[RDY_BIT] = ready;
  end

  // sound-side writes are accepted and dropped
  assign unused_snd = snd_wr_i ^ (^snd_addr_i[ADDR_W-1:DEC_W]);
endmodule

// File: rtl/snd_cmd_bridge_chk.sv
module snd_cmd_bridge_chk #(
  parameter int CMD_W   = 8,
  parameter int ADDR_W  = 16,
  parameter int DEC_W   = 8,
  parameter int STAT_W  = 16,
  parameter int RDY_BIT = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              host_wr_i,
  input logic [STAT_W-1:0] host_status_o,
  input logic [ADDR_W-1:0] snd_addr_i,
  input logic              snd_rd_i,
  input logic              snd_nmi_o
);
  logic ack_seen;
  assign ack_seen = snd_rd_i && (snd_addr_i[DEC_W-1:0] == 8'h0C);

  assert_nmi_follows_wr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_wr_i |=> snd_nmi_o);
  assert_nmi_only_after_wr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_wr_i |=> !snd_nmi_o);
  assert_wr_drops_ready_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_wr_i |=> !host_status_o[RDY_BIT]);
  assert_ack_raises_ready_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_seen && !host_wr_i) |=> host_status_o[RDY_BIT]);
  assert_wr_beats_ack_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_seen && host_wr_i) |=> !host_status_o[RDY_BIT]);
  assert_ready_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_wr_i && !ack_seen) |=> $stable(host_status_o));
endmodule

bind snd_cmd_bridge snd_cmd_bridge_chk #(
  .CMD_W(CMD_W), .ADDR_W(ADDR_W), .DEC_W(DEC_W), .STAT_W(STAT_W), .RDY_BIT(RDY_BIT)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .host_wr_i    (host_wr_i),
  .host_status_o(host_status_o),
  .snd_addr_i   (snd_addr_i),
  .snd_rd_i     (snd_rd_i),
  .snd_nmi_o    (snd_nmi_o)
);

// File: tb/sim_snd_cmd_bridge.sv
module sim_snd_cmd_bridge;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        host_wr_i = 1'b0;
  logic [15:0] host_wdata_i = '0;
  logic [15:0] host_status_o;
  logic [15:0] snd_addr_i = '0;
  logic        snd_rd_i = 1'b0;
  logic        snd_wr_i = 1'b0;
  logic [7:0]  snd_rdata_o;
  logic        snd_nmi_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk_i = ~clk_i;

  snd_cmd_bridge u0 (.*);

  // op: 0 host write, 1 sound read (check data), 2 sound write
  typedef struct packed {
    logic [1:0]  op;
    logic [15:0] addr;
    logic [15:0] data;
    logic [7:0]  exp;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 16'h0000, 16'hA55A, 8'h00},
    '{2'd1, 16'h0000, 16'h0000, 8'hA5},  // R1 R5
    '{2'd1, 16'h0004, 16'h0000, 8'h5A},  // R1 R5
    '{2'd1, 16'h0008, 16'h0000, 8'hFF},  // R5 unmapped
    '{2'd2, 16'h0000, 16'h0033, 8'h00},  // R6
    '{2'd1, 16'h0000, 16'h0000, 8'hA5},  // R6 slot 0 unchanged
    '{2'd0, 16'h0000, 16'h1234, 8'h00},
    '{2'd1, 16'h3400, 16'h0000, 8'h12},  // R4 alias
    '{2'd1, 16'hFF04, 16'h0000, 8'h34},  // R4 alias
    '{2'd1, 16'h0001, 16'h0000, 8'hFF},  // R5 unmapped
    '{2'd1, 16'h0104, 16'h0000, 8'h34}   // R4
  };

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [15:0] d);
    @(negedge clk_i);
    host_wr_i = 1'b1; host_wdata_i = d;
    @(negedge clk_i);
    host_wr_i = 1'b0;
    chk(snd_nmi_o === 1'b1, "R2", {15'd0, snd_nmi_o}, 16'd1);
    chk(host_status_o === 16'h0000, "R3", host_status_o, 16'h0000);
    @(negedge clk_i);
    chk(snd_nmi_o === 1'b0, "R2", {15'd0, snd_nmi_o}, 16'd0);
  endtask

  task automatic snd_read(input logic [15:0] a, input logic [7:0] e, input string req);
    @(negedge clk_i);
    snd_addr_i = a; snd_rd_i = 1'b1;
    #1;
    chk(snd_rdata_o === e, req, {8'd0, snd_rdata_o}, {8'd0, e});
    @(negedge clk_i);
    snd_rd_i = 1'b0;
  endtask

  initial begin
    #5000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #25;
    // R9 reset state
    chk(host_status_o === 16'h0020, "R9", host_status_o, 16'h0020);
    chk(snd_nmi_o === 1'b0, "R9", {15'd0, snd_nmi_o}, 16'd0);
    snd_addr_i = 16'h0000; #1;
    chk(snd_rdata_o === 8'h00, "R9", {8'd0, snd_rdata_o}, 16'h0000);
    snd_addr_i = 16'h0004; #1;
    chk(snd_rdata_o === 8'h00, "R9", {8'd0, snd_rdata_o}, 16'h0000);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        2'd0: host_write(VEC[i].data);
        2'd1: snd_read(VEC[i].addr, VEC[i].exp, "R1/R4/R5 table");
        default: begin
          @(negedge clk_i);
          snd_addr_i = VEC[i].addr; snd_wr_i = 1'b1;
          @(negedge clk_i);
          snd_wr_i = 1'b0;
        end
      endcase
    end

    // R6: write to ack address does not raise flag
    @(negedge clk_i);
    snd_addr_i = 16'h000C; snd_wr_i = 1'b1;
    @(negedge clk_i);
    snd_wr_i = 1'b0;
    chk(host_status_o[5] === 1'b0, "R6", host_status_o, 16'h0000);

    // R7 ack via aliased address, read data 0xFF
    snd_read(16'hAB0C, 8'hFF, "R7 data");
    chk(host_status_o === 16'h0020, "R7 R8 R4", host_status_o, 16'h0020);

    // R10 collision: write wins
    @(negedge clk_i);
    snd_addr_i = 16'h000C; snd_rd_i = 1'b1; host_wr_i = 1'b1; host_wdata_i = 16'hC3D4;
    @(negedge clk_i);
    snd_rd_i = 1'b0; host_wr_i = 1'b0;
    chk(host_status_o[5] === 1'b0, "R10", host_status_o, 16'h0000);
    snd_read(16'h0000, 8'hC3, "R1");
    snd_read(16'h0004, 8'hD4, "R1");

    // R2 back-to-back writes: one nmi cycle per write
    @(negedge clk_i);
    host_wr_i = 1'b1; host_wdata_i = 16'h0102;
    @(negedge clk_i);
    host_wdata_i = 16'h0304;
    chk(snd_nmi_o === 1'b1, "R2 b2b", {15'd0, snd_nmi_o}, 16'd1);
    @(negedge clk_i);
    host_wr_i = 1'b0;
    chk(snd_nmi_o === 1'b1, "R2 b2b", {15'd0, snd_nmi_o}, 16'd1);
    @(negedge clk_i);
    chk(snd_nmi_o === 1'b0, "R2 b2b", {15'd0, snd_nmi_o}, 16'd0);
    snd_read(16'h0000, 8'h03, "R1 last");

    // R8 ack then idle hold
    snd_read(16'h000C, 8'hFF, "R7");
    repeat (3) @(negedge clk_i);
    chk(host_status_o === 16'h0020, "R8", host_status_o, 16'h0020);

    // R9 asynchronous reset mid-run
    #3 rst_ni = 1'b0; #1;
    chk(host_status_o === 16'h0020, "R9 async", host_status_o, 16'h0020);
    snd_addr_i = 16'h0004; #1;
    chk(snd_rdata_o === 8'h00, "R9 async", {8'd0, snd_rdata_o}, 16'h0000);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule